// File: doc/BRIEF.md
# One-Time-Programmable Memory Slave Programming Controller

This controller sits inside a device that holds one-time-programmable memory. An external programmer drives it through two 8-bit input ports and three active-low control lines. A falling edge on the command strobe latches an address and an operation from the ports. The programmer then pulses the program line once for each word. In program mode, the data is on the ports when the pulse falls. The word is burned when the pulse rises, then read back and compared. In dump mode, the falling pulse reads the addressed word out. A separate active-low increment line steps the address to the next word without a new command.

The storage is modelled as a synchronous array that starts fully erased (all ones). Programming can only clear bits: the stored word becomes the old word ANDed with the new data. A word that asks for a 1 where a 0 is already burned therefore fails its verify.

Each verify raises or clears a per-word pass flag. A cumulative pass flag falls on the first failure and stays low until reset, which is the only way to leave the mode. All control lines pass through two-flop synchronizers, and edges are taken on the synchronized copies.

Top module: `otp_slave_prog`

## Requirements
- R1: After reset, verOk is 0, cumOk is 1, dumpData is 0, and every word of the array reads 16'hFFFF.
- R2: A falling edge of strobeN latches the command word W = {portHi, portLo}. The address is W[8:1]. W[0] selects the operation: 1 is program mode and 0 is dump mode.
- R3: In program mode, a falling edge of progN latches {portHi, portLo} as the data. The following rising edge writes it so that the stored word becomes old AND data, so no bit ever goes from 0 to 1.
- R4: In program mode, verOk goes low on the falling edge of progN. After the rising edge, the word is read back and verOk goes high only if the readback equals the latched data.
- R5: cumOk goes low on any failed verify and stays low until reset, even after later verifies pass.
- R6: In dump mode, a falling edge of progN places the addressed word on dumpData and writes nothing. dumpData also shows the readback word of each program verify, and it holds its value until the next read.
- R7: A falling edge of incN advances the address by one, and the address wraps from 255 to 0.
- R8: When strobeN and incN fall in the same synchronized cycle, the strobe's address is used and no increment happens.
- R9: Changing the ports with no strobe or program edge changes neither dumpData nor the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset; leaving reset enters the mode |
| strobeN | input | 1 | Command strobe, falling edge latches address and operation |
| progN | input | 1 | Program pulse, falling starts an operation, rising ends a program |
| incN | input | 1 | Active-low auto-increment, falling edge steps the address |
| portLo | input | 8 | Low byte of command or data word |
| portHi | input | 8 | High byte of command or data word |
| dumpData | output | 16 | Last word read from the array |
| verOk | output | 1 | Per-word verify pass flag |
| cumOk | output | 1 | Cumulative pass flag since reset |

## Verification
The bench reprograms a word with a 1 where a 0 is already burned. A design that overwrote the word instead of ANDing it would report a pass and leave the wrong contents. After that failure, a passing verify must not restore cumOk; a design that recomputed the flag per word would raise it again. Further checks cover:
- incrementing across address 255, where a design that did not wrap would read an unrelated word;
- a strobe and an increment arriving together, where the wrong priority shifts the address by one;
- reads in dump mode and bare port changes, which must leave the array untouched.

// File: rtl/slvprog_pkg.sv
package slvprog_pkg;
  typedef struct packed {
    logic latchCmd;
    logic latchData;
    logic incAddr;
    logic wrMem;
    logic rdMem;
    logic cmpNow;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_READ,
    ST_CMP
  } state_t;
endpackage

// File: rtl/slvprog_ctrl.sv
module slvprog_ctrl
  import slvprog_pkg::*;
#(
  parameter int SYNC_N = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    strobeN,
  input  logic    progN,
  input  logic    incN,
  input  logic    cmdBit,
  output strobe_t stb,
  output logic    modeProg
);
  logic [SYNC_N-1:0] rawIn, s1, s2, prev, fallE, riseE;
  assign rawIn = {incN, progN, strobeN};

  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1[i]   <= 1'b1;
        s2[i]   <= 1'b1;
        prev[i] <= 1'b1;
      end else begin
        s1[i]   <= rawIn[i];
        s2[i]   <= s1[i];
        prev[i] <= s2[i];
      end
    end
    assign fallE[i] = prev[i] & ~s2[i];
    assign riseE[i] = ~prev[i] & s2[i];
  end

  logic strobeFall, progFall, progRise, incFall;
  assign strobeFall = fallE[0];
  assign progFall   = fallE[1];
  assign progRise   = riseE[1];
  assign incFall    = fallE[2];

  state_t state, stateNxt;

  always_comb begin
    stb          = '0;
    stateNxt     = state;
    stb.latchCmd = strobeFall;
    stb.incAddr  = incFall & ~strobeFall;
    case (state)
      ST_IDLE: if (progFall) begin
        if (modeProg) begin
          stb.latchData = 1'b1;
          stateNxt      = ST_PULSE;
        end else begin
          stb.rdMem = 1'b1;
        end
      end
      ST_PULSE: if (progRise) begin
        stb.wrMem = 1'b1;
        stateNxt  = ST_READ;
      end
      ST_READ: begin
        stb.rdMem = 1'b1;
        stateNxt  = ST_CMP;
      end
      ST_CMP: begin
        stb.cmpNow = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeProg <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobeFall) modeProg <= cmdBit;
    end
  end

  // R6
  dump_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !modeProg) |=> !stb.wrMem);
endmodule

// File: rtl/slvprog_dpath.sv
module slvprog_dpath
  import slvprog_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PORT_W-1:0]     portLo,
  input  logic [PORT_W-1:0]     portHi,
  input  strobe_t               stb,
  output logic [2*PORT_W-1:0]   dumpData,
  output logic                  verOk,
  output logic                  cumOk
);
  localparam int WORD_W = 2 * PORT_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] portWord, dataReg, rdWord;
  logic [ADDR_W-1:0] addrReg;

  assign portWord = {portHi, portLo};
  assign dumpData = rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      rdWord  <= '0;
      verOk   <= 1'b0;
      cumOk   <= 1'b1;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (stb.latchCmd)     addrReg <= portWord[ADDR_W:1];
      else if (stb.incAddr) addrReg <= addrReg + 1'b1;
      if (stb.latchData) begin
        dataReg <= portWord;
        verOk   <= 1'b0;
      end
      if (stb.wrMem) mem[addrReg] <= mem[addrReg] & dataReg;
      if (stb.rdMem) rdWord <= mem[addrReg];
      if (stb.cmpNow) begin
        verOk <= (rdWord == dataReg);
        if (rdWord != dataReg) cumOk <= 1'b0;
      end
    end
  end

  // R3
  no_bit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMem |=> ((mem[$past(addrReg)] & ~$past(mem[addrReg])) == '0));

  // R5
  cum_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(cumOk));

  // R4
  ver_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchData |=> !verOk);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incAddr && !stb.latchCmd) |=> addrReg == $past(addrReg) + 1'b1);
endmodule

// File: rtl/otp_slave_prog.sv
module otp_slave_prog
  import slvprog_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strobeN,
  input  logic                progN,
  input  logic                incN,
  input  logic [PORT_W-1:0]   portLo,
  input  logic [PORT_W-1:0]   portHi,
  output logic [2*PORT_W-1:0] dumpData,
  output logic                verOk,
  output logic                cumOk
);
  strobe_t stb;
  logic    modeProg;

  slvprog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .progN(progN), .incN(incN),
    .cmdBit(portLo[0]), .stb(stb), .modeProg(modeProg)
  );

  slvprog_dpath #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .portLo(portLo), .portHi(portHi), .stb(stb),
    .dumpData(dumpData), .verOk(verOk), .cumOk(cumOk)
  );
endmodule

// File: tb/otp_slave_prog_tb.sv
module otp_slave_prog_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic strobeN = 1'b1, progN = 1'b1, incN = 1'b1;
  logic [7:0] portLo = '0, portHi = '0;
  logic [15:0] dumpData;
  logic verOk, cumOk;
  int errs = 0, checks = 0;
  logic [15:0] expMem [256];
  logic expCum = 1'b1;

  always #4 clk = ~clk;

  otp_slave_prog u_dut (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .progN(progN), .incN(incN),
    .portLo(portLo), .portHi(portHi), .dumpData(dumpData), .verOk(verOk), .cumOk(cumOk)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] addr, input logic prog);
    logic [15:0] w;
    w = {7'd0, addr, prog};
    portHi = w[15:8]; portLo = w[7:0];
    waitN(1); strobeN = 1'b0; waitN(4); strobeN = 1'b1; waitN(6);
  endtask

  task automatic pulse(input logic [15:0] d);
    portHi = d[15:8]; portLo = d[7:0];
    waitN(1); progN = 1'b0; waitN(4); progN = 1'b1; waitN(8);
  endtask

  task automatic inc();
    incN = 1'b0; waitN(4); incN = 1'b1; waitN(6);
  endtask

  task automatic progWord(input logic [7:0] a, input logic [15:0] d, input string req);
    logic exOk;
    cmd(a, 1'b1);
    pulse(d);
    expMem[a] = expMem[a] & d;
    exOk = (expMem[a] == d);
    if (!exOk) expCum = 1'b0;
    chk(verOk == exOk, {req, " verOk"}, {15'd0, verOk}, {15'd0, exOk});
    chk(cumOk == expCum, "R5 cumOk", {15'd0, cumOk}, {15'd0, expCum});
    chk(dumpData == expMem[a], "R3 readback", dumpData, expMem[a]);
  endtask

  task automatic dumpWord(input logic [7:0] a, input string req);
    cmd(a, 1'b0);
    pulse(16'h5A5A);
    chk(dumpData == expMem[a], req, dumpData, expMem[a]);
  endtask

  initial begin
    fork
      begin : wd
        #1500000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    join_none
    void'($urandom(32'h0000C0DE));
    for (int i = 0; i < 256; i++) expMem[i] = 16'hFFFF;
    waitN(3);
    // R1 reset state
    chk(verOk == 1'b0, "R1 verOk", {15'd0, verOk}, 16'd0);
    chk(cumOk == 1'b1, "R1 cumOk", {15'd0, cumOk}, 16'd1);
    chk(dumpData == 16'h0, "R1 dumpData", dumpData, 16'h0);
    rstN = 1'b1;
    waitN(3);
    dumpWord(8'd17, "R1 erased word");
    // R2 R3 R4 directed program
    progWord(8'd5, 16'hA5C3, "R4");
    dumpWord(8'd5, "R2 R6 dump after program");
    // R5 failure: set a burned bit back to 1
    progWord(8'd5, 16'hFFC3, "R4 fail");
    chk(cumOk == 1'b0, "R5 cleared", {15'd0, cumOk}, 16'd0);
    progWord(8'd6, 16'h1234, "R4 pass after fail");
    chk(cumOk == 1'b0, "R5 sticky", {15'd0, cumOk}, 16'd0);
    // R6 dump does not write
    dumpWord(8'd6, "R6 first read");
    dumpWord(8'd6, "R6 unchanged");
    // R7 wrap
    progWord(8'd0, 16'h0F0F, "R7 prep");
    cmd(8'd255, 1'b0);
    inc();
    pulse(16'h0);
    chk(dumpData == expMem[0], "R7 wrap", dumpData, expMem[0]);
    cmd(8'd5, 1'b0);
    inc();
    pulse(16'h0);
    chk(dumpData == expMem[6], "R7 step", dumpData, expMem[6]);
    // R8 strobe and inc together
    portHi = 8'h0; portLo = {7'd5, 1'b0} << 0;
    {portHi, portLo} = {7'd0, 8'd40, 1'b0};
    waitN(1); strobeN = 1'b0; incN = 1'b0; waitN(4); strobeN = 1'b1; incN = 1'b1; waitN(6);
    progWord(8'd40, 16'h00FF, "R8 prep");
    {portHi, portLo} = {7'd0, 8'd40, 1'b0};
    waitN(1); strobeN = 1'b0; incN = 1'b0; waitN(4); strobeN = 1'b1; incN = 1'b1; waitN(6);
    pulse(16'h0);
    chk(dumpData == expMem[40], "R8 priority", dumpData, expMem[40]);
    // R9 bare port changes
    for (int i = 0; i < 8; i++) begin
      portLo = 8'($urandom); portHi = 8'($urandom); waitN(2);
    end
    chk(dumpData == expMem[40], "R9 dumpData held", dumpData, expMem[40]);
    dumpWord(8'd40, "R9 array untouched");
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a;
      logic [15:0] d;
      a = 8'($urandom);
      d = ($urandom % 4 == 0) ? 16'($urandom) : (16'($urandom) & expMem[a]);
      progWord(a, d, "R3 R4 random");
      if (n % 3 == 0) dumpWord(a, "R6 random dump");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule